// File: doc/BRIEF.md
# CRC-protected command frame encoder

This block turns one register write for a daisy-chained battery monitor into a 32-bit serial frame. The caller supplies a 5-bit device address, a 6-bit register number, a data byte and a broadcast flag, then pulses a start strobe. The block packs these fields into a header and computes an 8-bit checksum over the header. It appends a fixed tail, then shifts the word out most significant bit first on an SPI mode 1 link, with chip select held low for the whole word.

A second input selects the fixed filler frame. The host must transmit this frame while it clocks a response out of the chain. When that input is set, the field inputs are ignored and the constant filler word is sent.

A busy output covers the whole transfer, and a start strobe that arrives while busy is high is dropped. The serial clock is made by a plain divider, and its half period is a parameter. The default, with a 125 MHz system clock, keeps the link just below 700 kHz.

Top module: `cmdframe_tx`

## Requirements
- R1: The frame carries the device address in bits 31:27, the register number in bits 26:21, the data byte in bits 20:13 and the broadcast flag in bit 12. Bit 11 is always 0.
- R2: Bits 10:3 hold a checksum computed over frame bits 31:11, split into three bytes: hi = bits 31:27 zero-extended to 8 bits, mid = bits 26:19, lo = bits 18:11. With S(v) meaning eight MSB-first shift steps of v, where each step XORs 0x2F into the result when the bit shifted out was 1, the checksum is S(S(hi) ^ mid) ^ lo.
- R3: Bits 2:0 of every frame are binary 010.
- R4: When `rd_fill` is 1 at the accepted start, the frame sent is 0xF800030A, whatever the field inputs hold.
- R5: The link is SPI mode 1. `sclk` idles low, `mosi` changes only together with a rising `sclk` edge, and bits leave MSB first, so the receiver samples each bit on the falling edge.
- R6: `cs_n` falls when a frame starts and rises after exactly 32 `sclk` pulses. `sclk` is low whenever `cs_n` is high.
- R7: A start seen while `busy` is 0 is accepted, and `busy` is 1 and `cs_n` is 0 in the next cycle. `busy` stays 1 until the frame ends. A start seen while `busy` is 1, including the last busy cycle, is ignored: no frame is added and the frame in flight is unchanged.
- R8: Each `sclk` high phase and low phase lasts `HALF_DIV` system clock cycles. The first rising edge comes `HALF_DIV` cycles after `cs_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send one frame |
| rd_fill | input | 1 | Send the fixed filler frame instead of the fields |
| dev_addr | input | 5 | Target device address |
| reg_addr | input | 6 | Target register number |
| wr_data | input | 8 | Data byte to write |
| bcast | input | 1 | Broadcast flag for all devices in the chain |
| busy | output | 1 | A frame is being sent |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two events can fall in the same cycle: the serialiser finishing its last half period, and a new start request. The bench provokes this by holding `start` high with a second set of fields through a whole frame, so the request is present in the final busy cycle and in the first idle one. The scoreboard must then see the first frame intact, followed by exactly one frame built from the second set of fields. It judges this by decoding `mosi` on every falling `sclk` edge and counting the frames.

// File: rtl/cft_pkg.sv
package cft_pkg;

    localparam int FRAME_W = 32;
    localparam int HDR_W   = 21;
    localparam int CRC_W   = 8;
    localparam int DEV_W   = 5;
    localparam int REG_W   = 6;
    localparam int DAT_W   = 8;
    localparam int TAIL_W  = 3;

    localparam logic [CRC_W-1:0]  CRC_POLY = 8'h2F;
    localparam logic [TAIL_W-1:0] TAIL_PAT = 3'b010;
    localparam logic [DEV_W-1:0]  FILL_DEV = 5'h1F;

    // fields supplied by the caller for one write
    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [REG_W-1:0] regno;
        logic [DAT_W-1:0] data;
        logic             bcast;
    } fields_t;

    // full frame, MSB first on the wire
    typedef struct packed {
        fields_t           hdr;
        logic              pad;
        logic [CRC_W-1:0]  crc;
        logic [TAIL_W-1:0] tail;
    } frame_t;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_RUN  = 2'd1
    } ser_state_e;

    // one MSB-first shift of the checksum register
    function automatic logic [CRC_W-1:0] crc_shift1(input logic [CRC_W-1:0] c);
        logic [CRC_W-1:0] s;
        s = {c[CRC_W-2:0], 1'b0};
        return c[CRC_W-1] ? (s ^ CRC_POLY) : s;
    endfunction

endpackage

// File: rtl/cft_crc_byte.sv
module cft_crc_byte
    import cft_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic [CRC_W-1:0] din,
    output logic [CRC_W-1:0] dout
);

    logic [CRC_W-1:0] stage [0:STEPS];

    assign stage[0] = din;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        assign stage[i+1] = crc_shift1(stage[i]);
    end

    assign dout = stage[STEPS];

endmodule

// File: rtl/cft_crc8.sv
module cft_crc8
    import cft_pkg::*;
#(
    parameter int IN_W = HDR_W
) (
    input  logic [IN_W-1:0]  hdr,
    output logic [CRC_W-1:0] crc
);

    localparam int NBYTES = (IN_W + 7) / 8;
    localparam int PAD_W  = NBYTES * 8;

    logic [PAD_W-1:0] padded;
    logic [CRC_W-1:0] acc [0:NBYTES-1];

    assign padded = PAD_W'(hdr);
    assign acc[0] = '0;

    // every byte except the last goes through the table step
    for (genvar k = 0; k < NBYTES - 1; k++) begin : g_byte
        logic [CRC_W-1:0] mixed;
        assign mixed = acc[k] ^ padded[(NBYTES-1-k)*8 +: 8];
        cft_crc_byte #(.STEPS(8)) u_step (
            .din  (mixed),
            .dout (acc[k+1])
        );
    end

    // the last byte is folded in without shifting
    assign crc = acc[NBYTES-1] ^ padded[7:0];

endmodule

// File: rtl/cft_framer.sv
module cft_framer
    import cft_pkg::*;
(
    input  fields_t              fields,
    input  logic                 rd_fill,
    output logic [FRAME_W-1:0]   frame
);

    fields_t          sel;
    logic [HDR_W-1:0] hdr_bits;
    logic [CRC_W-1:0] crc;
    frame_t           fr;

    always_comb begin
        if (rd_fill) begin
            sel.dev   = FILL_DEV;
            sel.regno = '0;
            sel.data  = '0;
            sel.bcast = 1'b0;
        end else begin
            sel = fields;
        end
    end

    assign hdr_bits = {sel, 1'b0};

    cft_crc8 #(.IN_W(HDR_W)) u_crc (
        .hdr (hdr_bits),
        .crc (crc)
    );

    always_comb begin
        fr.hdr  = sel;
        fr.pad  = 1'b0;
        fr.crc  = crc;
        fr.tail = TAIL_PAT;
    end

    assign frame = fr;

endmodule

// File: rtl/cft_serializer.sv
module cft_serializer
    import cft_pkg::*;
#(
    parameter int WORD_W   = FRAME_W,
    parameter int HALF_DIV = 90
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              active,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);

    localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int LAST_HS = 2 * WORD_W;
    localparam int HS_W    = $clog2(LAST_HS + 1);
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(HALF_DIV - 1);
    localparam logic [HS_W-1:0]  HS_END  = HS_W'(LAST_HS);

    ser_state_e        state;
    logic [WORD_W-1:0] sreg;
    logic [DIV_W-1:0]  div_cnt;
    logic [HS_W-1:0]   hs;
    logic              tick;

    assign tick   = (div_cnt == DIV_TOP);
    assign active = (state == SER_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SER_IDLE;
            sreg    <= '0;
            div_cnt <= '0;
            hs      <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            cs_n    <= 1'b1;
        end else if (state == SER_IDLE) begin
            if (load) begin
                state   <= SER_RUN;
                sreg    <= word;
                div_cnt <= '0;
                hs      <= '0;
                cs_n    <= 1'b0;
            end
        end else if (tick) begin
            div_cnt <= '0;
            hs      <= hs + 1'b1;
            if (hs == HS_END) begin
                // trailing half period done: release the select
                state <= SER_IDLE;
                cs_n  <= 1'b1;
            end else if (!hs[0]) begin
                sclk <= 1'b1;
                mosi <= sreg[WORD_W-1];
                sreg <= {sreg[WORD_W-2:0], 1'b0};
            end else begin
                sclk <= 1'b0;
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cmdframe_tx.sv
module cmdframe_tx
    import cft_pkg::*;
#(
    parameter int HALF_DIV = 90
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd_fill,
    input  logic [DEV_W-1:0] dev_addr,
    input  logic [REG_W-1:0] reg_addr,
    input  logic [DAT_W-1:0] wr_data,
    input  logic             bcast,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n
);

    fields_t              fields;
    logic [FRAME_W-1:0]   frame;
    logic                 accept;
    logic                 active;

    always_comb begin
        fields.dev   = dev_addr;
        fields.regno = reg_addr;
        fields.data  = wr_data;
        fields.bcast = bcast;
    end

    cft_framer u_framer (
        .fields  (fields),
        .rd_fill (rd_fill),
        .frame   (frame)
    );

    assign accept = start & ~active;

    cft_serializer #(
        .WORD_W   (FRAME_W),
        .HALF_DIV (HALF_DIV)
    ) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .word   (frame),
        .active (active),
        .sclk   (sclk),
        .mosi   (mosi),
        .cs_n   (cs_n)
    );

    assign busy = active;

endmodule

// File: rtl/cmdframe_tx_chk.sv
module cmdframe_tx_chk #(
    parameter int HALF_DIV = 90,
    parameter int WORD_W   = 32
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic sclk,
    input logic mosi,
    input logic cs_n
);

    localparam int HC_W = $clog2(HALF_DIV + 2) + 1;
    localparam int RC_W = $clog2(WORD_W + 2) + 1;
    localparam logic [HC_W-1:0] HC_MAX = {HC_W{1'b1}};

    logic            sclk_prev;
    logic [HC_W-1:0] hold_cnt;
    logic [RC_W-1:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            hold_cnt  <= '0;
            rise_cnt  <= '0;
        end else begin
            sclk_prev <= sclk;
            if (sclk != sclk_prev)
                hold_cnt <= HC_W'(1);
            else if (hold_cnt != HC_MAX)
                hold_cnt <= hold_cnt + 1'b1;
            if (cs_n)
                rise_cnt <= '0;
            else if (sclk && !sclk_prev)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    assert_edge_count_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (rise_cnt == RC_W'(WORD_W)));

    assert_mosi_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> $rose(sclk));

    assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !cs_n));

    assert_busy_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_half_period_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hold_cnt == HC_W'(HALF_DIV)));

endmodule

bind cmdframe_tx cmdframe_tx_chk #(
    .HALF_DIV (HALF_DIV),
    .WORD_W   (32)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n)
);

// File: tb/tb_cmdframe_tx.sv
module tb_cmdframe_tx;

    localparam int HD = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       rd_fill;
    logic [4:0] dev_addr;
    logic [5:0] reg_addr;
    logic [7:0] wr_data;
    logic       bcast;
    logic       busy;
    logic       sclk;
    logic       mosi;
    logic       cs_n;

    always #4 clk = ~clk;

    cmdframe_tx #(.HALF_DIV(HD)) dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rd_fill  (rd_fill),
        .dev_addr (dev_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .bcast    (bcast),
        .busy     (busy),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] tstep(input logic [7:0] v);
        logic [7:0] c;
        c = v;
        for (int i = 0; i < 8; i++)
            c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
        return c;
    endfunction

    // expected frame built from R1, R2, R3
    function automatic logic [31:0] model(input logic [4:0] d, input logic [5:0] r,
                                          input logic [7:0] v, input logic b);
        logic [31:0] w;
        logic [20:0] h;
        w = {d, r, v, b, 1'b0, 8'h00, 3'b010};
        h = w[31:11];
        w[10:3] = tstep(tstep({3'b000, h[20:16]}) ^ h[15:8]) ^ h[7:0];
        return w;
    endfunction

    // monitor: decodes the serial stream on falling sclk edges
    logic        prev_cs   = 1'b1;
    logic        prev_sclk = 1'b0;
    logic        prev_mosi = 1'b0;
    logic [31:0] rxword    = '0;
    int          nbits     = 0;
    int          hi_cnt    = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                nbits = 0;
                check(!sclk, "R5", "sclk idle at select", 32'(sclk), 32'd0);
            end
            if (!cs_n && prev_sclk && !sclk) begin
                rxword = {rxword[30:0], mosi};
                nbits++;
                check(hi_cnt == HD, "R8", "sclk high phase", 32'(hi_cnt), 32'(HD));
                check(mosi == prev_mosi, "R5", "mosi stable while sclk high",
                      32'(mosi), 32'(prev_mosi));
            end
            if (!prev_cs && cs_n) begin
                check(nbits == 32, "R6", "sclk pulses per frame", 32'(nbits), 32'd32);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "frame with no request", rxword, 32'hx);
                end else begin
                    automatic logic [31:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(rxword == e, t, "frame word", rxword, e);
                end
            end
            hi_cnt = sclk ? hi_cnt + 1 : 0;
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic drive(input logic [4:0] d, input logic [5:0] r, input logic [7:0] v,
                         input logic b, input logic f);
        dev_addr = d;
        reg_addr = r;
        wr_data  = v;
        bcast    = b;
        rd_fill  = f;
    endtask

    task automatic send(input logic [4:0] d, input logic [5:0] r, input logic [7:0] v,
                        input logic b, input logic f, input string tag);
        @(negedge clk);
        drive(d, r, v, b, f);
        start = 1'b1;
        exp_q.push_back(f ? 32'hF800030A : model(d, r, v, b));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check(busy && !cs_n, "R7", "busy and select after accept",
              {30'd0, busy, cs_n}, 32'd2);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: actual hung expected idle");
        finish_run();
    end

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        drive(5'h00, 6'h00, 8'h00, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(!busy, "R7", "reset busy", 32'(busy), 32'd0);
        check(cs_n && !sclk && !mosi, "R6", "reset link pins",
              {29'd0, cs_n, sclk, mosi}, 32'd4);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2: all-zero header gives a zero checksum
        send(5'h00, 6'h00, 8'h00, 1'b0, 1'b0, "R2");
        wait_idle();
        send(5'h1F, 6'h3F, 8'hFF, 1'b1, 1'b0, "R1");
        wait_idle();
        send(5'h03, 6'h14, 8'hA5, 1'b0, 1'b0, "R2");
        wait_idle();
        send(5'h0A, 6'h0D, 8'h3C, 1'b1, 1'b0, "R3");
        wait_idle();
        // R1: walking one across the device address field
        for (int i = 0; i < 5; i++) begin
            send(5'(1 << i), 6'(i), 8'(8'h80 >> i), 1'(i & 1), 1'b0, "R1");
            wait_idle();
        end
        // R4: explicit fields matching the filler, then filler with stray fields
        send(5'h1F, 6'h00, 8'h00, 1'b0, 1'b0, "R4");
        wait_idle();
        send(5'h05, 6'h2A, 8'h5A, 1'b1, 1'b1, "R4");
        wait_idle();

        // R7: start held through a frame and across its final busy cycle
        send(5'h11, 6'h22, 8'h69, 1'b0, 1'b0, "R7");
        drive(5'h0E, 6'h31, 8'hC3, 1'b1, 1'b0);
        start = 1'b1;
        while (busy) @(negedge clk);
        exp_q.push_back(model(5'h0E, 6'h31, 8'hC3, 1'b1));
        tag_q.push_back("R7");
        @(negedge clk);
        start = 1'b0;
        check(busy, "R7", "held start taken once idle", 32'(busy), 32'd1);
        wait_idle();
        repeat (4 * HD) @(negedge clk);
        check(exp_q.size() == 0, "R7", "frames still expected",
              32'(exp_q.size()), 32'd0);
        check(cs_n && !busy, "R6", "idle after last frame",
              {30'd0, cs_n, busy}, 32'd2);
        finish_run();
    end

endmodule